// File: doc/BRIEF.md
# Masked Vector Compress and Expand Unit

This unit rearranges the elements of a 512-bit vector under a per-element mask. The vector is seen either as sixteen 32-bit elements or as eight 64-bit elements. In expand mode the unit takes source elements in ascending order, starting at element 0, and places each one in the next position whose mask bit is set. It takes as many source elements as there are set mask bits. Positions with a clear mask bit become zero. In compress mode it does the reverse: it collects the elements whose mask bits are set and packs them, in ascending order, into the lowest positions. All positions above the packed group become zero.

Each destination position is chosen by a running count of the set mask bits below an element. The lane-to-lane mapping therefore depends on the data. A request enters through a valid/ready handshake. The result is held in a register and is flagged valid exactly one cycle after the request is accepted. A new request may be accepted in every cycle.

Top module: `vpk_unit`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `out_vec` is all zeros.
- R2: `in_ready` is 0 while `rst` is high and 1 otherwise. A request is accepted on a rising clock edge when `in_valid` and `in_ready` are both 1. `in_valid` during reset has no effect.
- R3: `out_valid` is 1 in the cycle after an accepted request and 0 after any cycle without one. `out_vec` keeps its value when no request is accepted.
- R4: Expand (`in_op`=0) with 32-bit elements (`in_wide`=0): element i sits in bits [32i+31:32i]. The k-th lowest set bit of `in_mask` receives source element k.
- R5: In expand mode, every element position whose mask bit is clear reads zero.
- R6: Compress (`in_op`=1): the source element at the k-th lowest set mask bit goes to destination element k, preserving ascending order.
- R7: In compress mode, all destination elements at or above the number of set mask bits read zero.
- R8: With `in_wide`=1, elements are 64 bits wide (element e in bits [64e+63:64e]). Only `in_mask[7:0]` is used, and `in_mask[15:8]` has no effect on the result.
- R9: A mask with no set bits among the used mask bits yields an all-zero `out_vec`, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_vec | input | 512 | Source vector |
| in_mask | input | 16 | Per-element select mask |
| in_op | input | 1 | 0 = expand, 1 = compress |
| in_wide | input | 1 | 0 = 32-bit elements, 1 = 64-bit elements |
| out_valid | output | 1 | Result register holds a new result |
| out_vec | output | 512 | Registered result vector |

## Verification
Two things can happen in the same cycle: the result register presents one request's output while a new request, possibly of the other mode or element width, is being accepted. The bench provokes this with back-to-back directed pairs, such as an expand followed at once by a compress, and with random streams where `in_valid` is mostly high. At every falling edge it compares the outputs against a reference computed from the request accepted one edge earlier. Idle gaps check that the held vector does not change when nothing is accepted.

// File: rtl/vpk_pkg.sv
package vpk_pkg;

    localparam int unsigned VEC_W  = 512;
    localparam int unsigned LANE_W = 32;

    typedef enum logic {
        OP_EXPAND   = 1'b0,
        OP_COMPRESS = 1'b1
    } vpk_op_e;

    typedef enum logic {
        EW_NARROW = 1'b0,
        EW_WIDE   = 1'b1
    } vpk_ew_e;

    // Count of set bits in a mask of up to 64 bits.
    function automatic int unsigned vpk_popcount(input logic [63:0] bits);
        int unsigned acc;
        acc = 0;
        for (int i = 0; i < 64; i++) begin
            acc += int'(bits[i]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/vpk_prefix.sv
// Exclusive prefix count: entry i holds the number of set bits below bit i.
module vpk_prefix #(
    parameter int unsigned N  = 16,
    parameter int unsigned CW = $clog2(N) + 1
) (
    input  logic [N-1:0]    mask,
    output logic [N*CW-1:0] pre
);

    always_comb begin
        logic [CW-1:0] run;
        run = '0;
        for (int i = 0; i < int'(N); i++) begin
            pre[i*CW +: CW] = run;
            run = run + CW'(mask[i]);
        end
    end

endmodule

// File: rtl/vpk_route.sv
// Data-dependent lane crossbar for one element width.
module vpk_route
    import vpk_pkg::*;
#(
    parameter int unsigned N = 16,
    parameter int unsigned W = 32
) (
    input  logic [N*W-1:0] src,
    input  logic [N-1:0]   mask,
    input  vpk_op_e        op,
    output logic [N*W-1:0] dst
);

    localparam int unsigned CW = $clog2(N) + 1;

    logic [N*CW-1:0] pre;
    logic [N*W-1:0]  exp_d;
    logic [N*W-1:0]  cmp_d;

    vpk_prefix #(.N(N), .CW(CW)) u_prefix (
        .mask (mask),
        .pre  (pre)
    );

    // Expand: destination i pulls source element pre[i] when selected.
    always_comb begin
        exp_d = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (mask[i]) begin
                for (int k = 0; k < int'(N); k++) begin
                    if (pre[i*CW +: CW] == CW'(k)) begin
                        exp_d[i*W +: W] = src[k*W +: W];
                    end
                end
            end
        end
    end

    // Compress: destination j collects the selected source with rank j.
    always_comb begin
        cmp_d = '0;
        for (int j = 0; j < int'(N); j++) begin
            for (int i = 0; i < int'(N); i++) begin
                if (mask[i] && (pre[i*CW +: CW] == CW'(j))) begin
                    cmp_d[j*W +: W] = src[i*W +: W];
                end
            end
        end
    end

    assign dst = (op == OP_COMPRESS) ? cmp_d : exp_d;

endmodule

// File: rtl/vpk_unit.sv
module vpk_unit
    import vpk_pkg::*;
#(
    parameter int unsigned VW = vpk_pkg::VEC_W,
    parameter int unsigned LW = vpk_pkg::LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [VW-1:0] in_vec,
    input  logic [VW/LW-1:0] in_mask,
    input  logic          in_op,
    input  logic          in_wide,
    output logic          out_valid,
    output logic [VW-1:0] out_vec
);

    localparam int unsigned LANES  = VW / LW;
    localparam int unsigned WLANES = LANES / 2;
    localparam int unsigned CNT_W  = $clog2(LANES) + 2;

    vpk_op_e       op_q;
    vpk_ew_e       ew_q;
    logic          accept;
    logic [VW-1:0] narrow_d;
    logic [VW-1:0] wide_d;
    logic [VW-1:0] next_d;

    assign op_q     = vpk_op_e'(in_op);
    assign ew_q     = vpk_ew_e'(in_wide);
    assign in_ready = !rst;
    assign accept   = in_valid && in_ready;

    vpk_route #(.N(LANES), .W(LW)) u_route_narrow (
        .src  (in_vec),
        .mask (in_mask),
        .op   (op_q),
        .dst  (narrow_d)
    );

    vpk_route #(.N(WLANES), .W(2*LW)) u_route_wide (
        .src  (in_vec),
        .mask (in_mask[WLANES-1:0]),
        .op   (op_q),
        .dst  (wide_d)
    );

    assign next_d = (ew_q == EW_WIDE) ? wide_d : narrow_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_vec <= next_d;
            end
        end
    end

    // ---------------- assertions ----------------
    logic [CNT_W-1:0] used_sub;
    logic [LANES-1:0] eff_mask;

    always_comb begin
        if (in_wide) begin
            used_sub = CNT_W'(2 * vpk_popcount(64'(in_mask[WLANES-1:0])));
            eff_mask = LANES'(in_mask[WLANES-1:0]);
        end else begin
            used_sub = CNT_W'(vpk_popcount(64'(in_mask)));
            eff_mask = in_mask;
        end
    end

    p_valid_after_accept_r3: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);
    p_no_valid_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !out_valid);
    p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(out_vec));
    p_empty_mask_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (accept && eff_mask == '0) |=> (out_vec == '0));

    for (genvar s = 0; s < int'(LANES); s++) begin : g_lane_chk
        p_expand_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
            (accept && !in_op && !(in_wide ? in_mask[s/2] : in_mask[s]))
            |=> (out_vec[s*LW +: LW] == '0));
        p_compress_tail_zero_r7: assert property (@(posedge clk) disable iff (rst)
            (accept && in_op && (CNT_W'(s) >= used_sub))
            |=> (out_vec[s*LW +: LW] == '0));
    end

endmodule

// File: tb/vpk_unit_tb.sv
module vpk_unit_tb;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [511:0] in_vec;
    logic [15:0]  in_mask;
    logic         in_op;
    logic         in_wide;
    logic         out_valid;
    logic [511:0] out_vec;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    logic         exp_valid;
    logic [511:0] exp_vec;
    string        exp_tag;

    always #2 clk = ~clk;

    vpk_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_vec(in_vec), .in_mask(in_mask), .in_op(in_op), .in_wide(in_wide),
        .out_valid(out_valid), .out_vec(out_vec)
    );

    function automatic logic [511:0] ref_model(input logic [511:0] v, input logic [15:0] m,
                                               input bit cmp, input bit wide);
        logic [511:0] r;
        int n, k, c;
        r = '0; c = 0;
        n = wide ? 8 : 16;
        k = wide ? 2 : 1;
        for (int e = 0; e < n; e++) begin
            if (m[e]) begin
                for (int s = 0; s < k; s++) begin
                    if (cmp) r[(c*k+s)*32 +: 32] = v[(e*k+s)*32 +: 32];
                    else     r[(e*k+s)*32 +: 32] = v[(c*k+s)*32 +: 32];
                end
                c++;
            end
        end
        return r;
    endfunction

    function automatic logic [511:0] rand_vec();
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check_vec(input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a falling edge: checks last cycle's result, then drives the next request.
    task automatic step(input bit v, input logic [511:0] d, input logic [15:0] m,
                        input bit cmp, input bit wide);
        logic [15:0] em;
        @(negedge clk);
        check_bit("R3 out_valid", out_valid, exp_valid);
        check_vec(exp_tag, out_vec, exp_vec);
        in_valid = v; in_vec = d; in_mask = m; in_op = cmp; in_wide = wide;
        exp_valid = v;
        if (v) begin
            exp_vec = ref_model(d, m, cmp, wide);
            em = wide ? {8'h00, m[7:0]} : m;
            if (em == 16'h0)  exp_tag = "R9 empty mask";
            else if (wide)    exp_tag = "R8 wide element";
            else if (cmp)     exp_tag = "R6/R7 compress";
            else              exp_tag = "R4/R5 expand";
        end else begin
            exp_tag = "R3 hold";
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; in_valid = 1'b1; in_vec = rand_vec(); in_mask = 16'hFFFF;
        in_op = 1'b0; in_wide = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_bit("R1 out_valid in reset", out_valid, 1'b0);
        check_vec("R1 out_vec in reset", out_vec, '0);
        check_bit("R2 in_ready in reset", in_ready, 1'b0);
        in_valid = 1'b0;
        rst = 1'b0;
        exp_valid = 1'b0; exp_vec = '0; exp_tag = "R1 after reset";
        @(negedge clk);
        check_bit("R2 in_ready after reset", in_ready, 1'b1);

        // Directed corners
        step(1, rand_vec(), 16'h0000, 0, 0);
        step(1, rand_vec(), 16'h0000, 1, 0);
        step(1, rand_vec(), 16'hFF00, 1, 1);   // R8: high bits only, wide -> empty
        step(1, rand_vec(), 16'hFFFF, 0, 0);
        step(1, rand_vec(), 16'hFFFF, 1, 0);
        step(1, rand_vec(), 16'h8000, 0, 0);
        step(1, rand_vec(), 16'h8000, 1, 0);
        step(1, rand_vec(), 16'h0001, 0, 0);
        step(1, rand_vec(), 16'hA5A5, 0, 0);   // expand then compress back-to-back
        step(1, rand_vec(), 16'hA5A5, 1, 0);
        step(1, rand_vec(), 16'hF0C3, 0, 1);
        step(1, rand_vec(), 16'h0FC3, 0, 1);   // R8: same low byte, other high byte
        step(1, rand_vec(), 16'h5A80, 1, 1);
        step(0, rand_vec(), 16'hFFFF, 1, 0);   // idle: hold
        step(0, rand_vec(), 16'h1234, 0, 0);

        // Constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] m;
            int sel;
            sel = $urandom_range(0, 3);
            case (sel)
                0: m = 16'($urandom);
                1: m = 16'($urandom) & 16'($urandom);
                2: m = 16'($urandom) | 16'($urandom);
                default: m = 16'(1) << $urandom_range(0, 15);
            endcase
            step(($urandom_range(0, 9) != 0), rand_vec(), m,
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        step(0, '0, '0, 0, 0);
        step(0, '0, '0, 0, 0);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule